// File: doc/BRIEF.md
# Skip Condition Evaluation Unit

This block turns one decoded compare, test or arithmetic-with-skip operation into a single request that the following instruction be skipped. With each strobe the caller presents an operation code together with every operand the operation might need: the accumulator, a register operand, an immediate byte, a byte read from working memory, the 16-bit extended accumulator, a 16-bit register pair, a selector, a flag vector and an interrupt-request flag vector. The unit picks the operands that the code calls for and evaluates the condition.

One cycle later it presents the registered skip request. For the arithmetic forms it also presents the sum or difference that the caller writes back. Every magnitude comparison treats its operands as unsigned. Operation codes without a skip condition give a low request and a zero result. Fetch, decode and the suppression of the following instruction belong to the surrounding pipeline.

Top module: `skip_eval_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `out_valid` is low, `skip` is low and `result` is zero.
- R2: Unsigned magnitude tests against the immediate. Code 1 skips when reg_opnd < imm. Code 2 skips when reg_opnd > imm. Code 7 skips when wmem < imm. Code 8 skips when wmem > imm.
- R3: Equality tests. Codes 3 and 4 compare reg_opnd with imm. Codes 9 and 10 compare wmem with imm. Codes 13 and 14 compare acc with reg_opnd. Codes 15 and 16 compare acc with wmem. The odd code of each pair (3, 9, 13, 15) skips on a match. The even code (4, 10, 14, 16) skips on a difference.
- R4: Mask tests. Code 5 skips when (reg_opnd & imm) is non-zero and code 6 skips when it is zero. Code 11 skips when (wmem & imm) is non-zero and code 12 skips when it is zero.
- R5: Code 17 gives result = (reg_opnd + acc) mod 256 in the low byte, with the upper byte zero. It skips only when the addition produces no carry out.
- R6: Code 18 gives result = (reg_opnd − acc) mod 256 and code 19 gives result = (reg_opnd − imm) mod 256, each with the upper byte zero. Each skips only when no borrow occurs, that is when reg_opnd is at least the subtrahend.
- R7: 16-bit unsigned compares of ea against rpair. Code 20 skips when ea equals rpair. Code 21 skips when ea is greater than rpair.
- R8: Code 22 gives result = (ea + rpair) mod 65536 and skips only when that addition produces no carry out.
- R9: Code 23 skips when flags[sel] is 1 and code 24 skips when flags[sel] is 0. A value of sel at or above NFLAG (default 8) reads as a flag of 0.
- R10: Code 25 skips when irq_flags[sel] is 1 and code 26 skips when irq_flags[sel] is 0. A value of sel at or above NIRQ (default 16) reads as 0.
- R11: Code 27 skips when bit sel[2:0] of wmem is set. The upper bit of sel is ignored.
- R12: Codes 0 and 28 to 31 give a low skip and a zero result. Every code other than 17, 18, 19 and 22 gives a zero result.
- R13: While rst_n is low, `out_valid` and `skip` are low and `result` is zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 5 | Operation code |
| acc | input | 8 | Accumulator |
| reg_opnd | input | 8 | Register operand |
| imm | input | 8 | Immediate byte |
| wmem | input | 8 | Working-memory byte |
| ea | input | 16 | Extended accumulator |
| rpair | input | 16 | Register pair |
| sel | input | 4 | Flag, interrupt-flag or bit selector |
| flags | input | 8 | Flag vector |
| irq_flags | input | 16 | Interrupt-request flag vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| skip | output | 1 | Skip request for the next instruction |
| result | output | 16 | Sum or difference for the arithmetic forms |

## Verification
The properties assume that the operands stay steady for the whole cycle in which in_valid is high. They judge each output against the inputs held in that strobed cycle, and they make no assumption about the inputs in idle cycles. The assertion on an out-of-range selector assumes nothing about the flag vector.

The stimulus changes inputs only on the falling edge, so every strobed cycle sees one coherent operand set. Idle cycles in the stimulus deliberately leave operands that would match the condition, which shows that only the strobe starts an evaluation.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;

   typedef enum logic [4:0] {
      OP_NOP      = 5'd0,
      OP_LT_RI    = 5'd1,
      OP_GT_RI    = 5'd2,
      OP_EQ_RI    = 5'd3,
      OP_NE_RI    = 5'd4,
      OP_ON_RI    = 5'd5,
      OP_OFF_RI   = 5'd6,
      OP_LT_WI    = 5'd7,
      OP_GT_WI    = 5'd8,
      OP_EQ_WI    = 5'd9,
      OP_NE_WI    = 5'd10,
      OP_ON_WI    = 5'd11,
      OP_OFF_WI   = 5'd12,
      OP_EQ_AR    = 5'd13,
      OP_NE_AR    = 5'd14,
      OP_EQ_AW    = 5'd15,
      OP_NE_AW    = 5'd16,
      OP_ADD_NC   = 5'd17,
      OP_SUB_NB   = 5'd18,
      OP_SUBI_NB  = 5'd19,
      OP_WEQ      = 5'd20,
      OP_WGT      = 5'd21,
      OP_WADD_NC  = 5'd22,
      OP_FLAG_SET = 5'd23,
      OP_FLAG_CLR = 5'd24,
      OP_IRQ_SET  = 5'd25,
      OP_IRQ_CLR  = 5'd26,
      OP_WBIT_SET = 5'd27
   } skip_op_e;

   typedef enum logic [3:0] {
      REL_NONE,
      REL_GT,
      REL_EQ,
      REL_NE,
      REL_ON,
      REL_OFF,
      REL_ARITH8,
      REL_WEQ,
      REL_WGT,
      REL_ARITH16,
      REL_FLAG1,
      REL_FLAG0,
      REL_IRQ1,
      REL_IRQ0,
      REL_BIT1
   } skip_rel_e;

   // selector width that covers the widest of the three selectable vectors
   function automatic int sel_width(input int nflag, input int nirq, input int dw);
      int m;
      m = nflag;
      if (nirq > m) m = nirq;
      if (dw > m) m = dw;
      return $clog2(m);
   endfunction

endpackage

// File: rtl/skip_magcmp.sv
module skip_magcmp #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         eq,
   output logic         gt
);
   localparam bit SPLIT = (W > 8) && ((W % 2) == 0);
   localparam int HW    = W / 2;

   generate
      if (SPLIT) begin : g_split
         logic hi_eq, hi_gt, lo_eq, lo_gt;
         assign hi_eq = (a[W-1:HW] == b[W-1:HW]);
         assign hi_gt = (a[W-1:HW] >  b[W-1:HW]);
         assign lo_eq = (a[HW-1:0] == b[HW-1:0]);
         assign lo_gt = (a[HW-1:0] >  b[HW-1:0]);
         assign eq    = hi_eq & lo_eq;
         assign gt    = hi_gt | (hi_eq & lo_gt);
      end else begin : g_flat
         assign eq = (a == b);
         assign gt = (a >  b);
      end
   endgenerate
endmodule

// File: rtl/skip_addsub.sv
module skip_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         no_carry
);
   logic [W:0] ext;

   always_comb begin
      if (sub) ext = {1'b0, a} - {1'b0, b};
      else     ext = {1'b0, a} + {1'b0, b};
   end

   assign res      = ext[W-1:0];
   assign no_carry = ~ext[W];
endmodule

// File: rtl/skip_bitpick.sv
module skip_bitpick #(
   parameter int N     = 8,
   parameter int SEL_W = 3
) (
   input  logic [N-1:0]     vec,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_o
);
   localparam int SPAN = 1 << SEL_W;

   generate
      if (SPAN < N) begin : g_bad
         $error("skip_bitpick: selector too narrow for vector");
      end else if (SPAN == N) begin : g_exact
         assign bit_o = vec[sel];
      end else begin : g_padded
         logic [SPAN-1:0] padded;
         assign padded = {{(SPAN - N){1'b0}}, vec};
         assign bit_o  = padded[sel];
      end
   endgenerate
endmodule

// File: rtl/skip_eval_unit.sv
module skip_eval_unit
   import skip_eval_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NFLAG  = 8,
   parameter int NIRQ   = 16,
   localparam int WIDE_W = 2 * DATA_W,
   localparam int SEL_W  = sel_width(NFLAG, NIRQ, DATA_W),
   localparam int BIT_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] reg_opnd,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] wmem,
   input  logic [WIDE_W-1:0] ea,
   input  logic [WIDE_W-1:0] rpair,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NFLAG-1:0]  flags,
   input  logic [NIRQ-1:0]   irq_flags,
   output logic              out_valid,
   output logic              skip,
   output logic [WIDE_W-1:0] result
);

   generate
      if (DATA_W < 2) begin : g_chk_dw
         $error("skip_eval_unit: DATA_W must be at least 2");
      end
      if (NFLAG < 1 || NIRQ < 1) begin : g_chk_vec
         $error("skip_eval_unit: flag vectors need at least one bit");
      end
   endgenerate

   // operand steering and relation decode
   logic [DATA_W-1:0] cmp_a, cmp_b, ar_b;
   logic              ar_sub;
   skip_rel_e         rel;

   always_comb begin
      cmp_a  = reg_opnd;
      cmp_b  = imm;
      ar_b   = acc;
      ar_sub = 1'b0;
      rel    = REL_NONE;
      case (op)
         OP_LT_RI:    begin cmp_a = imm; cmp_b = reg_opnd; rel = REL_GT; end
         OP_GT_RI:    rel = REL_GT;
         OP_EQ_RI:    rel = REL_EQ;
         OP_NE_RI:    rel = REL_NE;
         OP_ON_RI:    rel = REL_ON;
         OP_OFF_RI:   rel = REL_OFF;
         OP_LT_WI:    begin cmp_a = imm;  cmp_b = wmem; rel = REL_GT; end
         OP_GT_WI:    begin cmp_a = wmem; rel = REL_GT;  end
         OP_EQ_WI:    begin cmp_a = wmem; rel = REL_EQ;  end
         OP_NE_WI:    begin cmp_a = wmem; rel = REL_NE;  end
         OP_ON_WI:    begin cmp_a = wmem; rel = REL_ON;  end
         OP_OFF_WI:   begin cmp_a = wmem; rel = REL_OFF; end
         OP_EQ_AR:    begin cmp_a = acc; cmp_b = reg_opnd; rel = REL_EQ; end
         OP_NE_AR:    begin cmp_a = acc; cmp_b = reg_opnd; rel = REL_NE; end
         OP_EQ_AW:    begin cmp_a = acc; cmp_b = wmem; rel = REL_EQ; end
         OP_NE_AW:    begin cmp_a = acc; cmp_b = wmem; rel = REL_NE; end
         OP_ADD_NC:   rel = REL_ARITH8;
         OP_SUB_NB:   begin ar_sub = 1'b1; rel = REL_ARITH8; end
         OP_SUBI_NB:  begin ar_sub = 1'b1; ar_b = imm; rel = REL_ARITH8; end
         OP_WEQ:      rel = REL_WEQ;
         OP_WGT:      rel = REL_WGT;
         OP_WADD_NC:  rel = REL_ARITH16;
         OP_FLAG_SET: rel = REL_FLAG1;
         OP_FLAG_CLR: rel = REL_FLAG0;
         OP_IRQ_SET:  rel = REL_IRQ1;
         OP_IRQ_CLR:  rel = REL_IRQ0;
         OP_WBIT_SET: rel = REL_BIT1;
         default:     rel = REL_NONE;
      endcase
   end

   // evaluation datapath
   logic              eq8, gt8, eq16, gt16, mask_nz;
   logic              ok8, ok16, flag_bit, irq_bit, wbit;
   logic [DATA_W-1:0] res8;
   logic [WIDE_W-1:0] res16;

   skip_magcmp #(.W(DATA_W)) u_cmp_byte (
      .a(cmp_a), .b(cmp_b), .eq(eq8), .gt(gt8)
   );

   skip_magcmp #(.W(WIDE_W)) u_cmp_wide (
      .a(ea), .b(rpair), .eq(eq16), .gt(gt16)
   );

   assign mask_nz = |(cmp_a & cmp_b);

   skip_addsub #(.W(DATA_W)) u_arith_byte (
      .a(reg_opnd), .b(ar_b), .sub(ar_sub), .res(res8), .no_carry(ok8)
   );

   skip_addsub #(.W(WIDE_W)) u_arith_wide (
      .a(ea), .b(rpair), .sub(1'b0), .res(res16), .no_carry(ok16)
   );

   skip_bitpick #(.N(NFLAG), .SEL_W(SEL_W)) u_pick_flag (
      .vec(flags), .sel(sel), .bit_o(flag_bit)
   );

   skip_bitpick #(.N(NIRQ), .SEL_W(SEL_W)) u_pick_irq (
      .vec(irq_flags), .sel(sel), .bit_o(irq_bit)
   );

   skip_bitpick #(.N(DATA_W), .SEL_W(BIT_W)) u_pick_wbit (
      .vec(wmem), .sel(sel[BIT_W-1:0]), .bit_o(wbit)
   );

   logic              skip_c;
   logic [WIDE_W-1:0] result_c;

   always_comb begin
      case (rel)
         REL_GT:      skip_c = gt8;
         REL_EQ:      skip_c = eq8;
         REL_NE:      skip_c = ~eq8;
         REL_ON:      skip_c = mask_nz;
         REL_OFF:     skip_c = ~mask_nz;
         REL_ARITH8:  skip_c = ok8;
         REL_WEQ:     skip_c = eq16;
         REL_WGT:     skip_c = gt16;
         REL_ARITH16: skip_c = ok16;
         REL_FLAG1:   skip_c = flag_bit;
         REL_FLAG0:   skip_c = ~flag_bit;
         REL_IRQ1:    skip_c = irq_bit;
         REL_IRQ0:    skip_c = ~irq_bit;
         REL_BIT1:    skip_c = wbit;
         default:     skip_c = 1'b0;
      endcase
   end

   always_comb begin
      case (rel)
         REL_ARITH8:  result_c = {{DATA_W{1'b0}}, res8};
         REL_ARITH16: result_c = res16;
         default:     result_c = '0;
      endcase
   end

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         skip      <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         skip      <= in_valid & skip_c;
         result    <= in_valid ? result_c : '0;
      end
   end

endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk
   import skip_eval_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NFLAG  = 8,
   parameter int NIRQ   = 16,
   localparam int WIDE_W = 2 * DATA_W,
   localparam int SEL_W  = sel_width(NFLAG, NIRQ, DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [4:0]        op,
   input logic [DATA_W-1:0] acc,
   input logic [DATA_W-1:0] reg_opnd,
   input logic [DATA_W-1:0] imm,
   input logic [DATA_W-1:0] wmem,
   input logic [WIDE_W-1:0] ea,
   input logic [WIDE_W-1:0] rpair,
   input logic [SEL_W-1:0]  sel,
   input logic              out_valid,
   input logic              skip,
   input logic [WIDE_W-1:0] result
);
   logic flag_oor;
   assign flag_oor = (int'(sel) >= NFLAG);

   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!skip && result == '0));

   p_lt_unsigned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_LT_RI) |=> (skip == ($past(reg_opnd) < $past(imm))));

   p_eq_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_EQ_AR) |=> (skip == ($past(acc) == $past(reg_opnd))));

   p_off_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_OFF_WI) |=> (skip == (($past(wmem) & $past(imm)) == '0)));

   p_add_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_ADD_NC) |=>
         (skip == (result[DATA_W-1:0] >= $past(reg_opnd)) && result[WIDE_W-1:DATA_W] == '0));

   p_sub_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_SUB_NB) |=> (skip == ($past(reg_opnd) >= $past(acc))));

   p_wide_gt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_WGT) |=> (skip == ($past(ea) > $past(rpair))));

   p_wide_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_WADD_NC) |=> (skip == (result >= $past(rpair))));

   p_flag_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_FLAG_SET && flag_oor) |=> !skip);

   p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_NOP) |=> (!skip && result == '0));

endmodule

bind skip_eval_unit skip_eval_chk #(.DATA_W(DATA_W), .NFLAG(NFLAG), .NIRQ(NIRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
   .reg_opnd(reg_opnd), .imm(imm), .wmem(wmem), .ea(ea), .rpair(rpair),
   .sel(sel), .out_valid(out_valid), .skip(skip), .result(result)
);

// File: tb/skip_eval_unit_bench.sv
module skip_eval_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op = '0;
   logic [7:0]  acc = '0, reg_opnd = '0, imm = '0, wmem = '0;
   logic [15:0] ea = '0, rpair = '0;
   logic [3:0]  sel = '0;
   logic [7:0]  flags = 8'hA5;
   logic [15:0] irq_flags = 16'h8001;
   logic        out_valid, skip;
   logic [15:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   skip_eval_unit u_skip_eval_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
      .reg_opnd(reg_opnd), .imm(imm), .wmem(wmem), .ea(ea), .rpair(rpair),
      .sel(sel), .flags(flags), .irq_flags(irq_flags),
      .out_valid(out_valid), .skip(skip), .result(result)
   );

   typedef struct packed {
      logic [4:0]  op;
      logic [7:0]  a, r, i, w;
      logic [15:0] e, p;
      logic [3:0]  s;
      logic        xs;
      logic [15:0] xr;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 44;
   // flags = A5 (bit0 set, bit1 clear), irq_flags = 8001 (bit15 set, bit3 clear)
   localparam vec_t VT [NV] = '{
      // R2 unsigned magnitude
      '{5'd1,  8'h00, 8'h05, 8'h10, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd2},
      '{5'd1,  8'h00, 8'h10, 8'h10, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd2},
      '{5'd2,  8'h00, 8'hFF, 8'h7F, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd2},
      '{5'd2,  8'h00, 8'h7F, 8'h7F, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd2},
      '{5'd7,  8'h00, 8'h00, 8'h81, 8'h80, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd2},
      '{5'd8,  8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd2},
      // R3 equality pairs
      '{5'd3,  8'h00, 8'h3C, 8'h3C, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd3},
      '{5'd4,  8'h00, 8'h3C, 8'h3C, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd3},
      '{5'd9,  8'h00, 8'h00, 8'h13, 8'h12, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd3},
      '{5'd10, 8'h00, 8'h00, 8'h13, 8'h12, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd3},
      '{5'd13, 8'h55, 8'h55, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd3},
      '{5'd14, 8'h55, 8'h54, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd3},
      '{5'd15, 8'hAA, 8'h00, 8'h00, 8'hAB, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd3},
      '{5'd16, 8'hAA, 8'h00, 8'h00, 8'hAA, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd3},
      // R4 mask tests
      '{5'd5,  8'h00, 8'hF0, 8'h0F, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd4},
      '{5'd6,  8'h00, 8'hF0, 8'h0F, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd4},
      '{5'd11, 8'h00, 8'h00, 8'h01, 8'h81, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd4},
      '{5'd12, 8'h00, 8'h00, 8'h80, 8'h81, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd4},
      // R5 add, skip on no carry
      '{5'd17, 8'h01, 8'hFF, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd5},
      '{5'd17, 8'h10, 8'h20, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0030, 4'd5},
      // R6 subtract, skip on no borrow
      '{5'd18, 8'h06, 8'h05, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h00FF, 4'd6},
      '{5'd18, 8'h06, 8'h06, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd6},
      '{5'd19, 8'h00, 8'h80, 8'h7F, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0001, 4'd6},
      '{5'd19, 8'h00, 8'h00, 8'h01, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h00FF, 4'd6},
      // R7 wide compares
      '{5'd20, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h1234, 4'd0,  1'b1, 16'h0000, 4'd7},
      '{5'd20, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h1235, 4'd0,  1'b0, 16'h0000, 4'd7},
      '{5'd21, 8'h00, 8'h00, 8'h00, 8'h00, 16'h8000, 16'h7FFF, 4'd0,  1'b1, 16'h0000, 4'd7},
      '{5'd21, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h1234, 4'd0,  1'b0, 16'h0000, 4'd7},
      // R8 wide add
      '{5'd22, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 4'd0,  1'b0, 16'h0000, 4'd8},
      '{5'd22, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h0234, 4'd0,  1'b1, 16'h1234, 4'd8},
      // R9 flags, including out-of-range selector
      '{5'd23, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000, 4'd9},
      '{5'd23, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd1,  1'b0, 16'h0000, 4'd9},
      '{5'd24, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd1,  1'b1, 16'h0000, 4'd9},
      '{5'd23, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd9,  1'b0, 16'h0000, 4'd9},
      '{5'd24, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd9,  1'b1, 16'h0000, 4'd9},
      // R10 interrupt-request flags
      '{5'd25, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd15, 1'b1, 16'h0000, 4'd10},
      '{5'd26, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd15, 1'b0, 16'h0000, 4'd10},
      '{5'd25, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd3,  1'b0, 16'h0000, 4'd10},
      // R11 working-memory bit test
      '{5'd27, 8'h00, 8'h00, 8'h00, 8'h08, 16'h0000, 16'h0000, 4'd3,  1'b1, 16'h0000, 4'd11},
      '{5'd27, 8'h00, 8'h00, 8'h00, 8'h08, 16'h0000, 16'h0000, 4'd11, 1'b1, 16'h0000, 4'd11},
      '{5'd27, 8'h00, 8'h00, 8'h00, 8'hF7, 16'h0000, 16'h0000, 4'd3,  1'b0, 16'h0000, 4'd11},
      // R12 codes without a condition
      '{5'd0,  8'h3C, 8'h3C, 8'h3C, 8'h3C, 16'hFFFF, 16'h0001, 4'd0,  1'b0, 16'h0000, 4'd12},
      '{5'd31, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 4'd0,  1'b0, 16'h0000, 4'd12},
      '{5'd28, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000, 4'd12}
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op = v.op; acc = v.a; reg_opnd = v.r; imm = v.i; wmem = v.w;
      ea = v.e; rpair = v.p; sel = v.s; in_valid = 1'b1;
   endtask

   task automatic check_vec(input int idx);
      string t;
      t = $sformatf("R%0d vec%0d skip", VT[idx].rq, idx);
      check(t, {15'd0, skip}, {15'd0, VT[idx].xs});
      t = $sformatf("R%0d vec%0d result", VT[idx].rq, idx);
      check(t, result, VT[idx].xr);
      t = $sformatf("R1 vec%0d out_valid", idx);
      check(t, {15'd0, out_valid}, 16'd1);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      // R13: reset holds outputs low even with a strobe present
      op = 5'd3; reg_opnd = 8'h11; imm = 8'h11; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R13 reset out_valid", {15'd0, out_valid}, 16'd0);
      check("R13 reset skip", {15'd0, skip}, 16'd0);
      check("R13 reset result", result, 16'h0000);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {15'd0, out_valid}, 16'd0);

      // table, streamed back to back
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         if (k > 0) check_vec(k - 1);
         drive(VT[k]);
      end
      @(negedge clk);
      check_vec(NV - 1);

      // R1: matching operands without a strobe give nothing
      in_valid = 1'b0; op = 5'd3; reg_opnd = 8'h42; imm = 8'h42;
      @(negedge clk);
      check("R1 no strobe out_valid", {15'd0, out_valid}, 16'd0);
      @(negedge clk);
      check("R1 no strobe skip", {15'd0, skip}, 16'd0);

      // R1: single strobe produces exactly one result cycle
      in_valid = 1'b1; op = 5'd17; acc = 8'h01; reg_opnd = 8'h02;
      @(negedge clk);
      in_valid = 1'b0;
      check("R5 single strobe result", result, 16'h0003);
      check("R5 single strobe skip", {15'd0, skip}, 16'd1);
      @(negedge clk);
      check("R1 after strobe out_valid", {15'd0, out_valid}, 16'd0);
      check("R1 after strobe result", result, 16'h0000);

      // R13: asynchronous reset clears a held result
      in_valid = 1'b1; op = 5'd22; ea = 16'h0100; rpair = 16'h0200;
      @(negedge clk);
      check("R8 before reset result", result, 16'h0300);
      #2 rst_n = 1'b0;
      #1;
      check("R13 async reset result", result, 16'h0000);
      check("R13 async reset skip", {15'd0, skip}, 16'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule